// File: doc/BRIEF.md
# Linked Descriptor List Walker

This block walks a chain of transfer descriptors held in a 24-bit word memory and turns each one into a set of decoded transfer parameters for a separate datapath. Software loads the address of the first descriptor into a pointer register, then writes a start register. The walker reads the seven words of the descriptor, one read per cycle, and presents its fields. It holds them until the datapath signals that the transfer is finished.

Each descriptor begins with a link word. Its low 14 bits address the next descriptor, and bit 14, when set, marks the last descriptor of the chain. After the last transfer the walker returns to idle and raises an end-of-chain interrupt flag. The flag stays set until software clears it. The control word of each descriptor is split into its individual fields. The walker also derives the last address of the circular buffer from the buffer base and the stored size-minus-one.

Top module: `dsc_walker`

## Requirements
- R1: While reset is applied, and until the first start, `busy`, `irq_eol`, `mem_rd_en` and `xfer_valid` are all 0.
- R2: A register write to address 0xFFFFD4 while idle loads bits 13:0 of the data into the pointer register. A register write to address 0xFFFFD5 (any data) while idle starts a fetch. In the cycle after the edge that samples the start write, `mem_rd_en` is 1 with `mem_rd_addr` equal to the pointer. Seven reads follow on consecutive cycles at consecutive addresses, which wrap modulo 2^14.
- R3: Read data is taken one cycle after its read. `xfer_valid` rises at the eighth rising edge after the edge that sampled the start (or the done that began the fetch).
- R4: The control word (word 1) is split as follows: `xfer_interleave` = bit 0, `xfer_dir` = bit 1, `xfer_wb` = bit 4, `xfer_buf_sel` = bits 8:5, `xfer_fmt` = bits 12:10, `xfer_step` = bits 23:14. Bits 3:2, 9 and 13 are ignored.
- R5: While `xfer_valid` is 1, the descriptor words are presented on the outputs: word 2 on `xfer_count`, word 3 on `xfer_dsp_addr`, word 4 on `xfer_buf_off`, word 5 on `xfer_buf_base` and word 6 (size minus one) on `xfer_buf_size_m1`. `xfer_buf_last` equals word 5 plus word 6, modulo 2^24.
- R6: `xfer_valid` and every decoded field hold steady until `xfer_done` is sampled high. `xfer_valid` is 0 after that edge.
- R7: When the transfer finishes and link bit 14 is 0, the pointer register takes link bits 13:0. The next fetch begins in the cycle after the done edge at that address.
- R8: When the transfer finishes and link bit 14 is 1, the walker returns to idle (`busy` = 0) and sets `irq_eol` at the same edge.
- R9: `irq_eol` is cleared only by a register write to 0xFFFFC5 with data bit 7 set. A write there with bit 7 clear has no effect. If a set and a clear fall on the same edge, the set wins.
- R10: While busy, writes to the start and pointer registers are ignored. No extra reads occur, and the pointer is left as R7 leaves it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_wr_addr | input | 24 | Register write address |
| reg_wr_data | input | 24 | Register write data |
| mem_rd_en | output | 1 | Descriptor memory read enable |
| mem_rd_addr | output | 14 | Descriptor memory read address |
| mem_rd_data | input | 24 | Read data, valid one cycle after the read |
| busy | output | 1 | Walker is fetching or transferring |
| irq_eol | output | 1 | End-of-chain interrupt flag |
| xfer_valid | output | 1 | Decoded descriptor is presented |
| xfer_done | input | 1 | Datapath has finished the transfer |
| xfer_interleave | output | 1 | Address interleave flag |
| xfer_dir | output | 1 | Transfer direction |
| xfer_wb | output | 1 | Buffer offset writeback flag |
| xfer_buf_sel | output | 4 | Buffer select |
| xfer_fmt | output | 3 | Sample format |
| xfer_step | output | 10 | Address step size |
| xfer_count | output | 24 | Sample count |
| xfer_dsp_addr | output | 24 | Local memory address |
| xfer_buf_off | output | 24 | Buffer offset |
| xfer_buf_base | output | 24 | Buffer base |
| xfer_buf_size_m1 | output | 24 | Buffer size minus one |
| xfer_buf_last | output | 24 | Last buffer address (base + size minus one) |

## Verification
The first read is due in the cycle right after the edge that takes the start write or the done. `xfer_valid` is due exactly eight edges after that same edge. The interrupt flag and the return to idle are due at the done edge itself. The bench drives every input at a falling edge and counts falling edges from that point, so each result is checked at the first falling edge after its edge. The read addresses are logged at falling edges and compared only once `xfer_valid` is up, when no read is in flight.

// File: rtl/dsc_pkg.sv
package dsc_pkg;
  // descriptor layout (word order is decoded by the walker)
  localparam int BLK_WORDS = 7;
  localparam int W_LINK    = 0;
  localparam int W_CTRL    = 1;
  localparam int W_COUNT   = 2;
  localparam int W_DADDR   = 3;
  localparam int W_OFF     = 4;
  localparam int W_BASE    = 5;
  localparam int W_SIZE    = 6;

  // control word field positions and widths
  localparam int C_ILV  = 0;
  localparam int C_DIR  = 1;
  localparam int C_WB   = 4;
  localparam int C_BUF  = 5;
  localparam int C_FMT  = 10;
  localparam int C_STEP = 14;
  localparam int BUF_W  = 4;
  localparam int FMT_W  = 3;
  localparam int STEP_W = 10;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_FETCH = 2'd1,
    ST_XFER  = 2'd2
  } walk_state_t;

  typedef struct packed {
    logic [STEP_W-1:0] step;
    logic [FMT_W-1:0]  fmt;
    logic [BUF_W-1:0]  buf_sel;
    logic              wb;
    logic              dir;
    logic              ilv;
  } xfer_ctrl_t;
endpackage

// File: rtl/dsc_rst_sync.sv
module dsc_rst_sync (
  input  logic clk,
  input  logic rst_n_in,
  output logic rst_n_out
);
  logic meta_q;
  logic sync_q;

  always_ff @(posedge clk or negedge rst_n_in) begin
    if (!rst_n_in) begin
      meta_q <= 1'b0;
      sync_q <= 1'b0;
    end else begin
      meta_q <= 1'b1;
      sync_q <= meta_q;
    end
  end

  assign rst_n_out = sync_q;
endmodule

// File: rtl/dsc_regs.sv
module dsc_regs #(
  parameter int          ADDR_W     = 14,
  parameter int          DATA_W     = 24,
  parameter logic [23:0] PTR_ADDR   = 24'hFFFFD4,
  parameter logic [23:0] START_ADDR = 24'hFFFFD5,
  parameter logic [23:0] IRQ_ADDR   = 24'hFFFFC5,
  parameter int          IRQ_BIT    = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              idle,
  input  logic              link_load,
  input  logic [ADDR_W-1:0] link_addr,
  input  logic              eol_set,
  output logic [ADDR_W-1:0] ptr_q,
  output logic              start_req,
  output logic              irq_q
);
  logic              ptr_wr;
  logic              ptr_en;
  logic [ADDR_W-1:0] ptr_d;
  logic              irq_clr;
  logic              irq_en;
  logic              irq_d;

  always_comb begin
    ptr_wr    = wr_en && (wr_addr == PTR_ADDR) && idle;
    start_req = wr_en && (wr_addr == START_ADDR) && idle;
    irq_clr   = wr_en && (wr_addr == IRQ_ADDR) && wr_data[IRQ_BIT];
    // link load only happens while busy, so it never meets a software write
    ptr_en    = ptr_wr || link_load;
    ptr_d     = link_load ? link_addr : wr_data[ADDR_W-1:0];
    // a set takes priority over a clear on the same edge
    irq_en    = eol_set || irq_clr;
    irq_d     = eol_set;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr_q <= '0;
    end else if (ptr_en) begin
      ptr_q <= ptr_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_q <= 1'b0;
    end else if (irq_en) begin
      irq_q <= irq_d;
    end
  end
endmodule

// File: rtl/dsc_fetch_seq.sv
module dsc_fetch_seq
  import dsc_pkg::*;
#(
  parameter int ADDR_W  = 14,
  parameter int DATA_W  = 24,
  parameter int EOL_BIT = 14
) (
  input  logic                               clk,
  input  logic                               rst_n,
  input  logic                               start,
  input  logic [ADDR_W-1:0]                  start_addr,
  output logic                               rd_en,
  output logic [ADDR_W-1:0]                  rd_addr,
  input  logic [DATA_W-1:0]                  rd_data,
  input  logic                               done,
  output logic [BLK_WORDS-1:0][DATA_W-1:0]   blk_q,
  output logic                               xfer_valid,
  output logic                               idle,
  output logic                               link_load,
  output logic [ADDR_W-1:0]                  link_addr,
  output logic                               eol_set
);
  localparam int                IDX_W    = $clog2(BLK_WORDS + 1);
  localparam logic [IDX_W-1:0]  LAST_IDX = IDX_W'(BLK_WORDS - 1);

  walk_state_t       state_q, state_d;
  logic [IDX_W-1:0]  rd_idx_q, rd_idx_d;
  logic [IDX_W-1:0]  cap_idx_q, cap_idx_d;
  logic              cap_vld_q, cap_vld_d;
  logic [ADDR_W-1:0] base_q, base_d;
  logic              base_en;
  logic              eol_flag;

  assign eol_flag  = blk_q[W_LINK][EOL_BIT];
  assign link_addr = blk_q[W_LINK][ADDR_W-1:0];
  assign rd_addr   = base_q + ADDR_W'(rd_idx_q);

  always_comb begin
    state_d   = state_q;
    rd_idx_d  = rd_idx_q;
    base_d    = base_q;
    base_en   = 1'b0;
    rd_en     = 1'b0;
    cap_vld_d = 1'b0;
    cap_idx_d = rd_idx_q;
    link_load = 1'b0;
    eol_set   = 1'b0;
    case (state_q)
      ST_IDLE: begin
        if (start) begin
          state_d  = ST_FETCH;
          base_d   = start_addr;
          base_en  = 1'b1;
          rd_idx_d = '0;
        end
      end
      ST_FETCH: begin
        if (rd_idx_q <= LAST_IDX) begin
          rd_en    = 1'b1;
          rd_idx_d = rd_idx_q + 1'b1;
        end
        cap_vld_d = rd_en;
        if (cap_vld_q && (cap_idx_q == LAST_IDX)) begin
          state_d = ST_XFER;
        end
      end
      ST_XFER: begin
        if (done) begin
          if (eol_flag) begin
            state_d = ST_IDLE;
            eol_set = 1'b1;
          end else begin
            state_d   = ST_FETCH;
            base_d    = link_addr;
            base_en   = 1'b1;
            rd_idx_d  = '0;
            link_load = 1'b1;
          end
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= ST_IDLE;
      rd_idx_q  <= '0;
      cap_vld_q <= 1'b0;
      cap_idx_q <= '0;
    end else begin
      state_q   <= state_d;
      rd_idx_q  <= rd_idx_d;
      cap_vld_q <= cap_vld_d;
      cap_idx_q <= cap_idx_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q <= '0;
    end else if (base_en) begin
      base_q <= base_d;
    end
  end

  // one holding register per descriptor word, each with its own enable
  for (genvar k = 0; k < BLK_WORDS; k++) begin : g_word
    logic wen;
    assign wen = cap_vld_q && (cap_idx_q == IDX_W'(k));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        blk_q[k] <= '0;
      end else if (wen) begin
        blk_q[k] <= rd_data;
      end
    end
  end

  assign xfer_valid = (state_q == ST_XFER);
  assign idle       = (state_q == ST_IDLE);
endmodule

// File: rtl/dsc_ctrl_unpack.sv
module dsc_ctrl_unpack
  import dsc_pkg::*;
#(
  parameter int DATA_W = 24
) (
  input  logic [DATA_W-1:0] ctrl_w,
  input  logic [DATA_W-1:0] base_w,
  input  logic [DATA_W-1:0] size_m1_w,
  output xfer_ctrl_t        ctrl,
  output logic [DATA_W-1:0] buf_last
);
  always_comb begin
    ctrl.ilv     = ctrl_w[C_ILV];
    ctrl.dir     = ctrl_w[C_DIR];
    ctrl.wb      = ctrl_w[C_WB];
    ctrl.buf_sel = ctrl_w[C_BUF +: BUF_W];
    ctrl.fmt     = ctrl_w[C_FMT +: FMT_W];
    ctrl.step    = ctrl_w[C_STEP +: STEP_W];
    buf_last     = base_w + size_m1_w;
  end
endmodule

// File: rtl/dsc_walker.sv
module dsc_walker
  import dsc_pkg::*;
#(
  parameter int          ADDR_W    = 14,
  parameter int          DATA_W    = 24,
  parameter int          EOL_BIT   = 14,
  parameter logic [23:0] PTR_REG   = 24'hFFFFD4,
  parameter logic [23:0] START_REG = 24'hFFFFD5,
  parameter logic [23:0] IRQ_REG   = 24'hFFFFC5,
  parameter int          IRQ_BIT   = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr_en,
  input  logic [DATA_W-1:0] reg_wr_addr,
  input  logic [DATA_W-1:0] reg_wr_data,
  output logic              mem_rd_en,
  output logic [ADDR_W-1:0] mem_rd_addr,
  input  logic [DATA_W-1:0] mem_rd_data,
  output logic              busy,
  output logic              irq_eol,
  output logic              xfer_valid,
  input  logic              xfer_done,
  output logic              xfer_interleave,
  output logic              xfer_dir,
  output logic              xfer_wb,
  output logic [BUF_W-1:0]  xfer_buf_sel,
  output logic [FMT_W-1:0]  xfer_fmt,
  output logic [STEP_W-1:0] xfer_step,
  output logic [DATA_W-1:0] xfer_count,
  output logic [DATA_W-1:0] xfer_dsp_addr,
  output logic [DATA_W-1:0] xfer_buf_off,
  output logic [DATA_W-1:0] xfer_buf_base,
  output logic [DATA_W-1:0] xfer_buf_size_m1,
  output logic [DATA_W-1:0] xfer_buf_last
);
  logic                             rst_n_s;
  logic                             idle;
  logic                             start_req;
  logic                             link_load;
  logic                             eol_set;
  logic [ADDR_W-1:0]                link_addr;
  logic [ADDR_W-1:0]                ptr_q;
  logic [BLK_WORDS-1:0][DATA_W-1:0] blk;
  xfer_ctrl_t                       ctrl;

  dsc_rst_sync u_rst (
    .clk       (clk),
    .rst_n_in  (rst_n),
    .rst_n_out (rst_n_s)
  );

  dsc_regs #(
    .ADDR_W     (ADDR_W),
    .DATA_W     (DATA_W),
    .PTR_ADDR   (PTR_REG),
    .START_ADDR (START_REG),
    .IRQ_ADDR   (IRQ_REG),
    .IRQ_BIT    (IRQ_BIT)
  ) u_regs (
    .clk       (clk),
    .rst_n     (rst_n_s),
    .wr_en     (reg_wr_en),
    .wr_addr   (reg_wr_addr),
    .wr_data   (reg_wr_data),
    .idle      (idle),
    .link_load (link_load),
    .link_addr (link_addr),
    .eol_set   (eol_set),
    .ptr_q     (ptr_q),
    .start_req (start_req),
    .irq_q     (irq_eol)
  );

  dsc_fetch_seq #(
    .ADDR_W  (ADDR_W),
    .DATA_W  (DATA_W),
    .EOL_BIT (EOL_BIT)
  ) u_seq (
    .clk        (clk),
    .rst_n      (rst_n_s),
    .start      (start_req),
    .start_addr (ptr_q),
    .rd_en      (mem_rd_en),
    .rd_addr    (mem_rd_addr),
    .rd_data    (mem_rd_data),
    .done       (xfer_done),
    .blk_q      (blk),
    .xfer_valid (xfer_valid),
    .idle       (idle),
    .link_load  (link_load),
    .link_addr  (link_addr),
    .eol_set    (eol_set)
  );

  dsc_ctrl_unpack #(
    .DATA_W (DATA_W)
  ) u_unpack (
    .ctrl_w    (blk[W_CTRL]),
    .base_w    (blk[W_BASE]),
    .size_m1_w (blk[W_SIZE]),
    .ctrl      (ctrl),
    .buf_last  (xfer_buf_last)
  );

  assign busy             = !idle;
  assign xfer_interleave  = ctrl.ilv;
  assign xfer_dir         = ctrl.dir;
  assign xfer_wb          = ctrl.wb;
  assign xfer_buf_sel     = ctrl.buf_sel;
  assign xfer_fmt         = ctrl.fmt;
  assign xfer_step        = ctrl.step;
  assign xfer_count       = blk[W_COUNT];
  assign xfer_dsp_addr    = blk[W_DADDR];
  assign xfer_buf_off     = blk[W_OFF];
  assign xfer_buf_base    = blk[W_BASE];
  assign xfer_buf_size_m1 = blk[W_SIZE];
endmodule

// File: rtl/dsc_walker_chk.sv
module dsc_walker_chk #(
  parameter int          ADDR_W  = 14,
  parameter int          DATA_W  = 24,
  parameter logic [23:0] IRQ_REG = 24'hFFFFC5,
  parameter int          IRQ_BIT = 7
) (
  input logic              clk,
  input logic              rst_n,
  input logic              reg_wr_en,
  input logic [DATA_W-1:0] reg_wr_addr,
  input logic [DATA_W-1:0] reg_wr_data,
  input logic              mem_rd_en,
  input logic [ADDR_W-1:0] mem_rd_addr,
  input logic              busy,
  input logic              irq_eol,
  input logic              xfer_valid,
  input logic              xfer_done,
  input logic [DATA_W-1:0] xfer_count,
  input logic [DATA_W-1:0] xfer_dsp_addr,
  input logic [9:0]        xfer_step
);
  logic clr_wr;
  assign clr_wr = reg_wr_en && (reg_wr_addr == IRQ_REG) && reg_wr_data[IRQ_BIT];

  // R2
  rd_only_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd_en |-> busy);

  // R2
  rd_addr_seq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rd_en && $past(mem_rd_en)) |-> (mem_rd_addr == ($past(mem_rd_addr) + ADDR_W'(1))));

  // R3
  valid_after_reads_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(xfer_valid) |-> ($past(mem_rd_en, 2) && !$past(mem_rd_en)));

  // R6
  fields_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer_valid && !xfer_done) |=> (xfer_valid && $stable(xfer_count)
                                    && $stable(xfer_dsp_addr) && $stable(xfer_step)));

  // R6
  valid_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer_valid && xfer_done) |=> !xfer_valid);

  // R8
  irq_from_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_eol) |-> ($past(xfer_valid && xfer_done) && !busy));

  // R9
  irq_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_eol && !clr_wr) |=> irq_eol);

  // R9
  irq_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_wr && !busy) |=> !irq_eol);
endmodule

bind dsc_walker dsc_walker_chk #(
  .ADDR_W  (ADDR_W),
  .DATA_W  (DATA_W),
  .IRQ_REG (IRQ_REG),
  .IRQ_BIT (IRQ_BIT)
) chk_i (
  .clk           (clk),
  .rst_n         (rst_n),
  .reg_wr_en     (reg_wr_en),
  .reg_wr_addr   (reg_wr_addr),
  .reg_wr_data   (reg_wr_data),
  .mem_rd_en     (mem_rd_en),
  .mem_rd_addr   (mem_rd_addr),
  .busy          (busy),
  .irq_eol       (irq_eol),
  .xfer_valid    (xfer_valid),
  .xfer_done     (xfer_done),
  .xfer_count    (xfer_count),
  .xfer_dsp_addr (xfer_dsp_addr),
  .xfer_step     (xfer_step)
);

// File: tb/dsc_walker_tb.sv
module dsc_walker_tb_top;
  localparam int          CLK_PERIOD = 10;
  localparam logic [23:0] PTR_A   = 24'hFFFFD4;
  localparam logic [23:0] START_A = 24'hFFFFD5;
  localparam logic [23:0] IRQ_A   = 24'hFFFFC5;

  logic        clk;
  logic        rst_n;
  logic        reg_wr_en;
  logic [23:0] reg_wr_addr;
  logic [23:0] reg_wr_data;
  logic        mem_rd_en;
  logic [13:0] mem_rd_addr;
  logic [23:0] mem_rd_data;
  logic        busy;
  logic        irq_eol;
  logic        xfer_valid;
  logic        xfer_done;
  logic        xfer_interleave;
  logic        xfer_dir;
  logic        xfer_wb;
  logic [3:0]  xfer_buf_sel;
  logic [2:0]  xfer_fmt;
  logic [9:0]  xfer_step;
  logic [23:0] xfer_count;
  logic [23:0] xfer_dsp_addr;
  logic [23:0] xfer_buf_off;
  logic [23:0] xfer_buf_base;
  logic [23:0] xfer_buf_size_m1;
  logic [23:0] xfer_buf_last;

  int checks;
  int errors;
  int rd_n;
  int rd_seen;
  logic [13:0] rd_log [0:511];
  logic [23:0] mem [0:1023];

  dsc_walker dut_i (
    .clk(clk), .rst_n(rst_n),
    .reg_wr_en(reg_wr_en), .reg_wr_addr(reg_wr_addr), .reg_wr_data(reg_wr_data),
    .mem_rd_en(mem_rd_en), .mem_rd_addr(mem_rd_addr), .mem_rd_data(mem_rd_data),
    .busy(busy), .irq_eol(irq_eol), .xfer_valid(xfer_valid), .xfer_done(xfer_done),
    .xfer_interleave(xfer_interleave), .xfer_dir(xfer_dir), .xfer_wb(xfer_wb),
    .xfer_buf_sel(xfer_buf_sel), .xfer_fmt(xfer_fmt), .xfer_step(xfer_step),
    .xfer_count(xfer_count), .xfer_dsp_addr(xfer_dsp_addr), .xfer_buf_off(xfer_buf_off),
    .xfer_buf_base(xfer_buf_base), .xfer_buf_size_m1(xfer_buf_size_m1),
    .xfer_buf_last(xfer_buf_last)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  // memory model: one cycle read latency, 10-bit index of the 14-bit address
  always @(posedge clk) if (mem_rd_en) mem_rd_data <= mem[mem_rd_addr[9:0]];

  always @(negedge clk) begin
    if (rst_n && mem_rd_en) begin
      if (rd_n < 512) rd_log[rd_n] = mem_rd_addr;
      rd_n = rd_n + 1;
    end
  end

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic write_reg(input logic [23:0] a, input logic [23:0] d);
    @(negedge clk);
    reg_wr_en = 1'b1; reg_wr_addr = a; reg_wr_data = d;
    @(negedge clk);
    reg_wr_en = 1'b0;
  endtask

  task automatic build_block(input logic [13:0] a, input logic [13:0] nxt, input bit last);
    logic [23:0] r;
    for (int i = 1; i < 7; i++) mem[(int'(a) + i) & 1023] = 24'($urandom);
    r = 24'($urandom);
    mem[int'(a) & 1023] = {r[23:15], last, nxt};
  endtask

  task automatic start_fetch(input logic [13:0] a, input bit load_ptr);
    rd_seen = rd_n;
    if (load_ptr) write_reg(PTR_A, {10'h3A5, a});
    write_reg(START_A, 24'h0);
    chk("R2", "first read enable", 32'(mem_rd_en), 32'd1);
    chk("R2", "first read address", 32'(mem_rd_addr), 32'(a));
  endtask

  // mode 0: plain, 1: start and pointer writes while busy, 2: irq clear at the done edge
  task automatic serve_block(input logic [13:0] a, input logic [13:0] nxt, input bit last, input int mode);
    int cyc;
    int nrd;
    logic [23:0] w [0:6];
    for (int i = 0; i < 7; i++) w[i] = mem[(int'(a) + i) & 1023];
    cyc = 0;
    while (!xfer_valid && cyc < 100) begin @(negedge clk); cyc++; end
    chk("R3", "valid delay", 32'(cyc), 32'd8);
    chk("R2", "read count", 32'(rd_n - rd_seen), 32'd7);
    for (int i = 0; i < 7; i++)
      if (rd_seen + i < 512)
        chk("R2", "read address", 32'(rd_log[rd_seen + i]), 32'((int'(a) + i) & 16383));
    chk("R4", "flags", {29'd0, xfer_wb, xfer_dir, xfer_interleave}, {29'd0, w[1][4], w[1][1], w[1][0]});
    chk("R4", "buf_sel/fmt", {25'd0, xfer_buf_sel, xfer_fmt}, {25'd0, w[1][8:5], w[1][12:10]});
    chk("R4", "step", 32'(xfer_step), 32'(w[1][23:14]));
    chk("R5", "count", 32'(xfer_count), 32'(w[2]));
    chk("R5", "dsp addr", 32'(xfer_dsp_addr), 32'(w[3]));
    chk("R5", "offset", 32'(xfer_buf_off), 32'(w[4]));
    chk("R5", "base/size", {8'd0, xfer_buf_base}, {8'd0, w[5]});
    chk("R5", "size_m1", 32'(xfer_buf_size_m1), 32'(w[6]));
    chk("R5", "buffer last", 32'(xfer_buf_last), 32'(24'(w[5] + w[6])));
    rd_seen = rd_n;
    if (mode == 1) begin
      nrd = rd_n;
      write_reg(START_A, 24'h0);
      write_reg(PTR_A, 24'h000155);
      repeat (2) @(negedge clk);
      chk("R10", "no reads on busy start", 32'(rd_n - nrd), 32'd0);
      chk("R10", "still presenting", 32'(xfer_valid), 32'd1);
    end
    repeat ($urandom % 4) @(negedge clk);
    chk("R6", "valid held", 32'(xfer_valid), 32'd1);
    chk("R6", "count held", 32'(xfer_count), 32'(w[2]));
    chk("R6", "step held", 32'(xfer_step), 32'(w[1][23:14]));
    xfer_done = 1'b1;
    if (mode == 2) begin
      reg_wr_en = 1'b1; reg_wr_addr = IRQ_A; reg_wr_data = 24'h000080;
    end
    @(negedge clk);
    xfer_done = 1'b0;
    reg_wr_en = 1'b0;
    chk("R6", "valid dropped", 32'(xfer_valid), 32'd0);
    if (!last) begin
      chk("R7", "link read enable", 32'(mem_rd_en), 32'd1);
      chk("R7", "link read address", 32'(mem_rd_addr), 32'(nxt));
      chk("R7", "no irq mid chain", 32'(irq_eol), 32'd0);
    end else begin
      chk("R8", "idle at end", 32'(busy), 32'd0);
      chk(mode == 2 ? "R9" : "R8", "irq set", 32'(irq_eol), 32'd1);
    end
  endtask

  task automatic clear_irq();
    write_reg(IRQ_A, 24'h000080);
    chk("R9", "irq cleared", 32'(irq_eol), 32'd0);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    errors++; checks++;
    $display("FAIL watchdog: actual=running expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [13:0] addrs [0:3];
    int nblk;
    int slot;
    void'($urandom(32'd20240611));
    checks = 0; errors = 0; rd_n = 0; rd_seen = 0;
    for (int i = 0; i < 1024; i++) mem[i] = 24'($urandom);
    rst_n = 1'b0; reg_wr_en = 1'b0; reg_wr_addr = '0; reg_wr_data = '0; xfer_done = 1'b0;
    repeat (3) @(negedge clk);
    chk("R1", "busy in reset", 32'(busy), 32'd0);
    chk("R1", "irq in reset", 32'(irq_eol), 32'd0);
    chk("R1", "outputs in reset", {30'd0, mem_rd_en, xfer_valid}, 32'd0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R1", "idle after reset", {30'd0, busy, mem_rd_en}, 32'd0);

    // single block, then irq clear variants
    build_block(14'h040, 14'h000, 1'b1);
    start_fetch(14'h040, 1'b1);
    serve_block(14'h040, 14'h000, 1'b1, 0);
    write_reg(IRQ_A, 24'hFFFF7F);
    chk("R9", "bit7 clear write ignored", 32'(irq_eol), 32'd1);
    clear_irq();

    // random chains
    for (int c = 0; c < 8; c++) begin
      nblk = 1 + int'($urandom % 4);
      slot = int'($urandom % 128);
      for (int k = 0; k < nblk; k++) addrs[k] = 14'(((slot + k * 9) % 128) * 8);
      for (int k = 0; k < nblk; k++)
        build_block(addrs[k], (k == nblk - 1) ? 14'(($urandom % 512) * 2) : addrs[k + 1], k == nblk - 1);
      start_fetch(addrs[0], 1'b1);
      for (int k = 0; k < nblk; k++)
        serve_block(addrs[k], (k == nblk - 1) ? 14'h0 : addrs[k + 1], k == nblk - 1, 0);
      clear_irq();
    end

    // address wrap at the top of the 14-bit space
    build_block(14'h3FFC, 14'h000, 1'b1);
    start_fetch(14'h3FFC, 1'b1);
    serve_block(14'h3FFC, 14'h000, 1'b1, 0);
    clear_irq();

    // writes while busy are ignored; pointer ends on the last linked block
    build_block(14'h100, 14'h180, 1'b0);
    build_block(14'h180, 14'h000, 1'b1);
    start_fetch(14'h100, 1'b1);
    serve_block(14'h100, 14'h180, 1'b0, 1);
    serve_block(14'h180, 14'h000, 1'b1, 0);
    clear_irq();
    start_fetch(14'h180, 1'b0);
    serve_block(14'h180, 14'h000, 1'b1, 0);
    clear_irq();

    // set wins over a clear on the same edge
    build_block(14'h200, 14'h000, 1'b1);
    start_fetch(14'h200, 1'b1);
    serve_block(14'h200, 14'h000, 1'b1, 2);
    clear_irq();

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule